// File: doc/BRIEF.md
# Prioritised Physical Memory Protection Access Checker

This block decides whether one memory access may go ahead. Its inputs are the access (byte address, size in bytes, requested read/write/execute mask, and whether the requester runs in machine mode) and the protection state it guards: one configuration byte and one decoded inclusive address window per entry, plus three security control bits. Its outputs are the permission mask that applies to the access and a single grant flag.

The entries are searched from index 0 upward, and the first active entry that the access touches decides the result. Both the first byte and the last byte of the access are compared against each window. When no active entry is touched, a default policy applies. That policy depends on the security bits and the requester's mode. Two permission schemes are built in. The normal scheme gives machine mode full rights unless the entry is locked. The lockdown scheme maps lock and read/write/execute to a fixed permission for each mode.

The decision logic is combinational. The parameter `OUT_REG` selects whether the result is taken straight from that logic or held in an output register. The access path has no handshake: a new access may be presented in every cycle, and the block never applies back-pressure.

Top module: `pmp_access_checker`

## Requirements
- R1: Entries are tested in rising index order. An entry is active when its mode field (cfg bits 4:3) is non-zero. The lowest-indexed active entry whose window contains any byte of the access alone sets the result, and inactive entries are skipped whatever their bounds.
- R2: If exactly one of the first and last byte lies inside the window of the deciding entry (window bounds inclusive), `allow_o` is 0 and `grant_o` is 0.
- R3: With no deciding entry and `sec_mmwp_i` set, `allow_o` is 0 and `grant_o` is 0.
- R4: With no deciding entry, `sec_mmwp_i` clear and `sec_mml_i` set, the default behaves as follows. A machine-mode access that requests no execute gets `allow_o`=3'b011 and a grant. Every other access gets `allow_o`=0 and no grant.
- R5: With no deciding entry and both `sec_mmwp_i` and `sec_mml_i` clear, machine mode gets `allow_o`=3'b111 and a grant. Lower modes get `allow_o`=0 and no grant.
- R6: Without lockdown, a fully containing entry gives machine mode `allow_o`=3'b111 unless the entry is locked (cfg bit 7). Lower modes, and machine mode on a locked entry, get cfg bits 2:0. Permission bit 0 is read, bit 1 is write and bit 2 is execute, both in cfg and in `allow_o`.
- R7: While `sec_rlb_i` is set, every entry counts as unlocked for the R6 rule.
- R8: With `sec_mml_i` set, a machine-mode hit is looked up with index k = L*8+R*4+W*2+X. Indices 0, 1, 4, 5, 6, 7 and 8 give none. Indices 2, 3 and 14 give RW. Indices 9 and 10 give X. Indices 11 and 13 give RX. Indices 12 and 15 give R.
- R9: With `sec_mml_i` set, a lower-mode hit uses the same index. Indices 0, 8, 9, 12, 13 and 14 give none. Indices 1, 10 and 11 give X. Indices 2, 4 and 15 give R. Indices 3 and 6 give RW. Index 5 gives RX. Index 7 gives RWX.
- R10: `grant_o` is 1 only if every bit of `acc_req_i` is present in `allow_o`, and on a full hit it is 1 exactly in that case.
- R11: The last byte is `acc_addr_i + acc_size_i - 1`, with `acc_size_i` equal to 1, 2 or 4.
- R12: With `OUT_REG`=1, the outputs show the decision for the inputs sampled at the previous rising clock edge.
- R13: While `rst_n` is low, the registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr_i | input | XLEN | First byte address of the access |
| acc_size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| acc_req_i | input | 3 | Requested permissions: bit0 read, bit1 write, bit2 execute |
| acc_mmode_i | input | 1 | 1 = requester runs in machine mode |
| sec_mmwp_i | input | 1 | Default deny for all modes |
| sec_mml_i | input | 1 | Lockdown permission scheme and default |
| sec_rlb_i | input | 1 | Treat all locks as cleared |
| ent_cfg_i | input | NENT*8 | Entry config bytes, entry i at bits 8i+7:8i |
| ent_lo_i | input | NENT*XLEN | Inclusive window start per entry |
| ent_hi_i | input | NENT*XLEN | Inclusive window end per entry |
| allow_o | output | 3 | Permission mask applied to the access |
| grant_o | output | 1 | Access allowed |

## Verification
The assertions assume the following about the inputs. `acc_size_i` is always 1, 2 or 4. The entry tables and security bits hold steady across each clock edge in which a decision is captured. Windows may overlap, be empty, or belong to inactive entries. The stimulus changes inputs only on falling edges and draws sizes from {1, 2, 4}. Windows are placed in a narrow address band so that overlaps, straddles and gaps between entries occur often.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;
  localparam int CFG_W    = 8;
  localparam int PERM_W   = 3;
  localparam int BIT_R    = 0;
  localparam int BIT_W    = 1;
  localparam int BIT_X    = 2;
  localparam int BIT_LOCK = 7;
  localparam int MODE_LO  = 3;
  typedef logic [PERM_W-1:0] perm_t;
  localparam perm_t P_NONE = 3'b000;
  localparam perm_t P_RW   = 3'b011;
  localparam perm_t P_ALL  = 3'b111;
endpackage

// File: rtl/pmpc_match.sv
module pmpc_match #(
  parameter int XLEN = 32
) (
  input  logic [7:0]      cfg_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] first_i,
  input  logic [XLEN-1:0] last_i,
  output logic            full_o,
  output logic            part_o
);
  import pmpc_pkg::*;
  logic active, in_first, in_last;
  assign active   = |cfg_i[MODE_LO+1:MODE_LO];
  assign in_first = (first_i >= lo_i) && (first_i <= hi_i);
  assign in_last  = (last_i >= lo_i) && (last_i <= hi_i);
  assign full_o   = active && in_first && in_last;
  assign part_o   = active && (in_first ^ in_last);
endmodule

// File: rtl/pmpc_perm.sv
module pmpc_perm (
  input  logic         [7:0] cfg_i,
  input  logic               mmode_i,
  input  logic               mml_i,
  input  logic               rlb_i,
  output pmpc_pkg::perm_t    perm_o
);
  import pmpc_pkg::*;
  logic [3:0] idx;
  logic       locked;
  perm_t      m_tab, u_tab, legacy;

  assign idx    = {cfg_i[BIT_LOCK], cfg_i[BIT_R], cfg_i[BIT_W], cfg_i[BIT_X]};
  assign locked = cfg_i[BIT_LOCK] && !rlb_i;

  always_comb begin
    unique case (idx)
      4'd2, 4'd3, 4'd14: m_tab = P_RW;
      4'd9, 4'd10:       m_tab = 3'b100;
      4'd11, 4'd13:      m_tab = 3'b101;
      4'd12, 4'd15:      m_tab = 3'b001;
      default:           m_tab = P_NONE;
    endcase
  end

  always_comb begin
    unique case (idx)
      4'd1, 4'd10, 4'd11: u_tab = 3'b100;
      4'd2, 4'd4, 4'd15:  u_tab = 3'b001;
      4'd3, 4'd6:         u_tab = P_RW;
      4'd5:               u_tab = 3'b101;
      4'd7:               u_tab = P_ALL;
      default:            u_tab = P_NONE;
    endcase
  end

  assign legacy = (mmode_i && !locked) ? P_ALL : cfg_i[PERM_W-1:0];
  assign perm_o = !mml_i ? legacy : (mmode_i ? m_tab : u_tab);
endmodule

// File: rtl/pmpc_select.sv
module pmpc_select #(
  parameter int NENT = 16
) (
  input  logic [NENT-1:0]   full_i,
  input  logic [NENT-1:0]   part_i,
  input  logic [NENT*3-1:0] perm_i,
  output logic              found_o,
  output logic              part_o,
  output logic [2:0]        perm_o
);
  always_comb begin
    found_o = 1'b0;
    part_o  = 1'b0;
    perm_o  = 3'b000;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (full_i[i] || part_i[i]) begin
        found_o = full_i[i];
        part_o  = part_i[i];
        perm_o  = perm_i[i*3 +: 3];
      end
    end
  end
endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker #(
  parameter int XLEN    = 32,
  parameter int NENT    = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   acc_addr_i,
  input  logic [2:0]        acc_size_i,
  input  logic [2:0]        acc_req_i,
  input  logic              acc_mmode_i,
  input  logic              sec_mmwp_i,
  input  logic              sec_mml_i,
  input  logic              sec_rlb_i,
  input  logic [NENT*8-1:0]    ent_cfg_i,
  input  logic [NENT*XLEN-1:0] ent_lo_i,
  input  logic [NENT*XLEN-1:0] ent_hi_i,
  output logic [2:0]        allow_o,
  output logic              grant_o
);
  import pmpc_pkg::*;
  localparam int PW = NENT * PERM_W;

  logic [XLEN-1:0] last_addr;
  logic [NENT-1:0] full_v, part_v;
  logic [PW-1:0]   perm_v;
  logic            found, part_hit;
  perm_t           sel_perm, dflt_perm, al_c;
  logic            dflt_g, g_c;

  assign last_addr = acc_addr_i + XLEN'(acc_size_i) - XLEN'(1);

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    pmpc_match #(.XLEN(XLEN)) u_match (
      .cfg_i  (ent_cfg_i[g*8 +: 8]),
      .lo_i   (ent_lo_i[g*XLEN +: XLEN]),
      .hi_i   (ent_hi_i[g*XLEN +: XLEN]),
      .first_i(acc_addr_i),
      .last_i (last_addr),
      .full_o (full_v[g]),
      .part_o (part_v[g])
    );
    pmpc_perm u_perm (
      .cfg_i  (ent_cfg_i[g*8 +: 8]),
      .mmode_i(acc_mmode_i),
      .mml_i  (sec_mml_i),
      .rlb_i  (sec_rlb_i),
      .perm_o (perm_v[g*PERM_W +: PERM_W])
    );
  end

  pmpc_select #(.NENT(NENT)) u_sel (
    .full_i (full_v),
    .part_i (part_v),
    .perm_i (perm_v),
    .found_o(found),
    .part_o (part_hit),
    .perm_o (sel_perm)
  );

  always_comb begin
    dflt_perm = P_NONE;
    dflt_g    = 1'b0;
    if (sec_mmwp_i) begin
      dflt_perm = P_NONE;
    end else if (sec_mml_i) begin
      if (acc_mmode_i && !acc_req_i[BIT_X]) begin
        dflt_perm = P_RW;
        dflt_g    = 1'b1;
      end
    end else if (acc_mmode_i) begin
      dflt_perm = P_ALL;
      dflt_g    = 1'b1;
    end
  end

  always_comb begin
    if (part_hit) begin
      al_c = P_NONE;
      g_c  = 1'b0;
    end else if (found) begin
      al_c = sel_perm;
      g_c  = ((acc_req_i & sel_perm) == acc_req_i);
    end else begin
      al_c = dflt_perm;
      g_c  = dflt_g;
    end
  end

  if (OUT_REG) begin : g_reg
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        allow_o <= 3'b000;
        grant_o <= 1'b0;
        seen_q  <= 1'b0;
      end else begin
        allow_o <= al_c;
        grant_o <= g_c;
        seen_q  <= 1'b1;
      end
    end
    p_reg_delay_r12: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q |=> (allow_o == $past(al_c)) && (grant_o == $past(g_c)));
  end else begin : g_comb
    assign allow_o = al_c;
    assign grant_o = g_c;
  end

  p_grant_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    g_c |-> ((acc_req_i & al_c) == acc_req_i));
  p_straddle_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
    part_hit |-> (al_c == P_NONE) && !g_c);
  p_one_outcome_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && part_hit));
  p_wp_deny_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!found && !part_hit && sec_mmwp_i) |-> (al_c == P_NONE) && !g_c);
  p_lock_dflt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!found && !part_hit && !sec_mmwp_i && sec_mml_i && acc_req_i[BIT_X]) |-> !g_c);
  p_lower_dflt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!found && !part_hit && !acc_mmode_i) |-> !g_c);
endmodule

// File: tb/pmp_access_checker_bench.sv
module pmp_access_checker_bench;
  localparam int XLEN = 32;
  localparam int N    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [XLEN-1:0] addr;
  logic [2:0]      size, req;
  logic            mmode, mmwp, mml, rlb;
  logic [7:0]      cfg_a [N];
  logic [XLEN-1:0] lo_a [N];
  logic [XLEN-1:0] hi_a [N];
  logic [N*8-1:0]    cfg_f;
  logic [N*XLEN-1:0] lo_f, hi_f;
  logic [2:0]      allow;
  logic            grant;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_f[i*8 +: 8]       = cfg_a[i];
      lo_f[i*XLEN +: XLEN]  = lo_a[i];
      hi_f[i*XLEN +: XLEN]  = hi_a[i];
    end
  end

  pmp_access_checker #(.XLEN(XLEN), .NENT(N), .OUT_REG(1'b1)) u_pmp_access_checker (
    .clk(clk), .rst_n(rst_n), .acc_addr_i(addr), .acc_size_i(size), .acc_req_i(req),
    .acc_mmode_i(mmode), .sec_mmwp_i(mmwp), .sec_mml_i(mml), .sec_rlb_i(rlb),
    .ent_cfg_i(cfg_f), .ent_lo_i(lo_f), .ent_hi_i(hi_f), .allow_o(allow), .grant_o(grant)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // lockdown tables, bit0 R, bit1 W, bit2 X
  logic [2:0] tab_m [16] = '{0,0,3,3,0,0,0,0,0,4,4,5,1,5,3,1};
  logic [2:0] tab_u [16] = '{0,4,1,3,1,5,3,7,0,0,4,4,0,0,0,1};

  task automatic model(output logic [2:0] al, output logic g, output string tag);
    logic [XLEN-1:0] last;
    last = addr + size - 1;
    for (int i = 0; i < N; i++) begin
      bit s, e;
      int k;
      if (cfg_a[i][4:3] == 2'b00) continue;
      s = (addr >= lo_a[i]) && (addr <= hi_a[i]);
      e = (last >= lo_a[i]) && (last <= hi_a[i]);
      if (s != e) begin al = 0; g = 0; tag = "R2"; return; end
      if (s) begin
        k = cfg_a[i][7]*8 + cfg_a[i][0]*4 + cfg_a[i][1]*2 + cfg_a[i][2];
        if (mml) begin
          al  = mmode ? tab_m[k] : tab_u[k];
          tag = mmode ? "R8" : "R9";
        end else begin
          bit lk;
          lk  = cfg_a[i][7] && !rlb;
          al  = (mmode && !lk) ? 3'b111 : cfg_a[i][2:0];
          tag = (rlb && cfg_a[i][7]) ? "R7" : "R6";
        end
        g = ((req & al) == req);
        return;
      end
    end
    if (mmwp) begin al = 0; g = 0; tag = "R3"; end
    else if (mml) begin
      g = mmode && !req[2]; al = g ? 3'b011 : 3'b000; tag = "R4";
    end else begin
      g = mmode; al = mmode ? 3'b111 : 3'b000; tag = "R5";
    end
  endtask

  // inputs are applied at a falling edge; the registered result is checked one clock later
  task automatic run(input string force_tag);
    logic [2:0] eal;
    logic eg;
    string tag;
    model(eal, eg, tag);
    if (force_tag != "") tag = force_tag;
    @(negedge clk);
    checks++;
    if (allow !== eal) begin
      errors++;
      $display("FAIL %s allow actual=%0d expected=%0d", tag, allow, eal);
    end
    checks++;
    if (grant !== eg) begin
      errors++;
      $display("FAIL R10/%s grant actual=%0d expected=%0d", tag, grant, eg);
    end
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      cfg_a[i] = 8'h00; lo_a[i] = '0; hi_a[i] = '1;
    end
    mmwp = 0; mml = 0; rlb = 0;
  endtask

  function automatic logic [7:0] mk(bit l, logic [1:0] a, logic [2:0] p);
    return {l, 2'b00, a, p};
  endfunction

  initial begin
    clear_all();
    addr = 32'h100; size = 3'd4; req = 3'b111; mmode = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (allow !== 3'b000 || grant !== 1'b0) begin
      errors++;
      $display("FAIL R13 reset actual=%0d/%0d expected=0/0", allow, grant);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // defaults
    run("R5");
    mmode = 0; req = 3'b001; run("R5");
    mmwp = 1; mmode = 1; run("R3");
    mmwp = 0; mml = 1; req = 3'b011; run("R4");
    req = 3'b100; run("R4");
    mmode = 0; req = 3'b001; run("R4");
    mml = 0;

    // priority: inactive entry 0 skipped, entry 2 decides over 5
    lo_a[0] = 32'h100; hi_a[0] = 32'h1FF;
    cfg_a[2] = mk(0, 2'b01, 3'b001); lo_a[2] = 32'h100; hi_a[2] = 32'h1FF;
    cfg_a[5] = mk(0, 2'b11, 3'b111); lo_a[5] = 32'h100; hi_a[5] = 32'h1FF;
    addr = 32'h140; size = 3'd4; req = 3'b010; mmode = 0; run("R1");
    req = 3'b001; run("R1");

    // straddle and size handling
    clear_all();
    cfg_a[3] = mk(0, 2'b10, 3'b111); lo_a[3] = 32'h100; hi_a[3] = 32'h103;
    addr = 32'h102; size = 3'd4; req = 3'b001; mmode = 1; run("R2");
    size = 3'd2; run("R11");
    size = 3'd1; addr = 32'h103; mmode = 0; run("R11");
    addr = 32'h0FF; size = 3'd2; run("R11");

    // lock and lock bypass
    clear_all();
    cfg_a[1] = mk(1, 2'b01, 3'b001); lo_a[1] = 32'h200; hi_a[1] = 32'h2FF;
    addr = 32'h210; size = 3'd4; mmode = 1; req = 3'b100; run("R6");
    rlb = 1; run("R7");
    rlb = 0; cfg_a[1] = mk(0, 2'b01, 3'b001); run("R6");

    // lockdown table sweep
    for (int k = 0; k < 16; k++) begin
      cfg_a[1] = {k[3], 2'b00, 2'b01, k[0], k[1], k[2]};
      mml = 1;
      for (int m = 0; m < 2; m++) begin
        mmode = m[0];
        for (int r = 0; r < 8; r++) begin
          req = r[2:0];
          run(m ? "R8" : "R9");
        end
      end
    end

    // random sweep
    for (int t = 0; t < 3000; t++) begin
      for (int i = 0; i < N; i++) begin
        cfg_a[i] = 8'($urandom);
        if ($urandom_range(0, 2) == 0) cfg_a[i][4:3] = 2'b00;
        lo_a[i] = 32'h8000_0000 + $urandom_range(0, 95);
        hi_a[i] = lo_a[i] + $urandom_range(0, 31);
      end
      addr  = 32'h8000_0000 + $urandom_range(0, 140);
      case ($urandom_range(0, 2))
        0: size = 3'd1;
        1: size = 3'd2;
        default: size = 3'd4;
      endcase
      req   = 3'($urandom);
      mmode = 1'($urandom);
      mmwp  = ($urandom_range(0, 7) == 0);
      mml   = 1'($urandom);
      rlb   = 1'($urandom);
      run("");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule